// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block sits between a synchronous host and one external asynchronous static RAM of 32K words by 8 bits. The host presents single-beat read or write requests. The controller turns each one into a sequence on the active-low chip-select, output-enable and write-strobe lines. It holds the address and write data steady on the RAM pins, and it enables its own data-bus driver only while a write strobe is in progress. Read data is sampled from the RAM data pins at the end of the access window. The host receives it together with a one-cycle valid pulse.

All RAM timing is counted in whole clock cycles and set by parameters: the read access window, the write strobe width and the idle gap after a read. The defaults suit a 100 MHz clock and a RAM with 12 ns access and a 10 ns minimum write pulse. A write first spends one cycle with the chip selected and the write strobe high, so the address settles before the strobe falls. The write strobe, the chip select and the bus driver all release on the same clock edge, which meets the zero hold and zero recovery limits. After a read, every strobe stays high for the turnaround cycles so that the RAM has released the bus before anything else happens.

Top module: `asram_port`

## Requirements
- R1: While reset is held and in the first cycle after it, ready is 1, the three strobes are 1 (inactive), the bus driver enable is 0 and rvalid is 0.
- R2: A read accepted at a clock edge keeps chip select and output enable low with the write strobe high for exactly RD_CYC cycles. rdata takes the value on the RAM data input at the edge that ends that window, and the value must be on the input only while output enable is low.
- R3: The bus driver enable is 1 only while the write strobe is low, and never while output enable is low.
- R4: A write spends one cycle with chip select low and both output enable and write strobe high. It then holds the write strobe low for exactly WR_CYC cycles, after which all three strobes go high together.
- R5: The RAM address does not change while chip select stays low, even if the host address changes during the operation.
- R6: ready is 0 from the accepting edge until the operation ends. A read is busy for RD_CYC+TURN_CYC cycles and a write for WR_CYC+1 cycles. A request raised while ready is 0 is ignored and writes nothing.
- R7: rvalid is a single-cycle pulse, given once per read, in the cycle right after the access window, and never for a write.
- R8: After a read, chip select and output enable are high for TURN_CYC cycles before the next operation can start, also when a write follows at once.
- R9: While the write strobe is low, the RAM data output carries the write data and the RAM address carries the write address that the host presented at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, taken when ready is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Host word address |
| wdata | input | 8 | Host write data |
| ready | output | 1 | 1 when idle and able to take a request |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | One-cycle read-data valid pulse |
| mem_addr | output | 15 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_o | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable of the bus driver toward the RAM |
| mem_dq_i | input | 8 | Data from the RAM |

## Verification
A bench model of the RAM presents its stored byte only while output enable is low and shows a marker value otherwise. A read whose capture edge is off by one cycle therefore returns the marker instead of the data. Writes and reads alternate over the lowest and highest addresses and over addresses whose low bytes differ, so the tests can tell a write to the wrong location from a missing write, and an overwrite from a stale value. Read-then-write and write-then-read pairs run back to back to measure the turnaround gap and the busy length. A request raised in the middle of a read, with a different address and write data, shows whether requests made while busy are really ignored and whether the RAM address stays fixed.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_TURN = 3'd2,
      ST_WSET = 3'd3,
      ST_WPUL = 3'd4
   } asram_st_e;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic dq_oe;
   } asram_pins_t;

   // Pin levels belonging to each sequencer state.
   function automatic asram_pins_t pins_of(asram_st_e st);
      asram_pins_t p;
      p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      case (st)
         ST_RD: begin
            p.ce_n = 1'b0;
            p.oe_n = 1'b0;
         end
         ST_WSET: begin
            p.ce_n = 1'b0;
         end
         ST_WPUL: begin
            p.ce_n  = 1'b0;
            p.we_n  = 1'b0;
            p.dq_oe = 1'b1;
         end
         default: ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
   import asram_pkg::*;
#(
   parameter int RD_CYC   = 2,
   parameter int WR_CYC   = 1,
   parameter int TURN_CYC = 1,
   parameter int CW       = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          we,
   input  logic          cnt_zero,
   output logic          cnt_load,
   output logic [CW-1:0] cnt_val,
   output asram_st_e     st_q,
   output asram_st_e     st_d,
   output logic          accept,
   output logic          capture,
   output logic          ready
);

   localparam logic [CW-1:0] RD_LOAD   = CW'(RD_CYC - 1);
   localparam logic [CW-1:0] WR_LOAD   = CW'(WR_CYC - 1);
   localparam logic [CW-1:0] TURN_LOAD = CW'(TURN_CYC - 1);

   always_comb begin
      st_d     = st_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (req) begin
               accept = 1'b1;
               if (we) begin
                  st_d = ST_WSET;
               end else begin
                  st_d     = ST_RD;
                  cnt_load = 1'b1;
                  cnt_val  = RD_LOAD;
               end
            end
         end
         ST_RD: begin
            if (cnt_zero) begin
               capture  = 1'b1;
               st_d     = ST_TURN;
               cnt_load = 1'b1;
               cnt_val  = TURN_LOAD;
            end
         end
         ST_TURN: begin
            if (cnt_zero)
               st_d = ST_IDLE;
         end
         ST_WSET: begin
            st_d     = ST_WPUL;
            cnt_load = 1'b1;
            cnt_val  = WR_LOAD;
         end
         ST_WPUL: begin
            if (cnt_zero)
               st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= ST_IDLE;
      else
         st_q <= st_d;
   end

   assign ready = (st_q == ST_IDLE);

   // R6: taking a request always leaves the idle state on the next cycle
   a_r6_busy_after_accept : assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> !ready);

   // R2: a capture only ever happens out of the access window
   a_r2_capture_in_read : assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> (st_q == ST_RD) && cnt_zero);

endmodule

// File: rtl/asram_rcap.sv
module asram_rcap #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= capture;
         if (capture)
            rdata <= dq_in;
      end
   end

   // R7: valid lasts a single cycle
   a_r7_rvalid_single : assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);

   // R2: returned data stays put between pulses
   a_r2_rdata_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> $stable(rdata));

endmodule

// File: rtl/asram_pins.sv
module asram_pins
   import asram_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter bit PARK_ZERO  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  asram_st_e         st_d,
   input  logic              accept,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [7:0]        mem_dq_o,
   output logic              mem_dq_oe
);

   asram_pins_t pins_q;
   logic [7:0]  wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pins_q <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      else
         pins_q <= pins_of(st_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         wdata_q  <= '0;
      end else if (accept) begin
         mem_addr <= addr;
         wdata_q  <= wdata;
      end
   end

   assign mem_ce_n  = pins_q.ce_n;
   assign mem_oe_n  = pins_q.oe_n;
   assign mem_we_n  = pins_q.we_n;
   assign mem_dq_oe = pins_q.dq_oe;

   generate
      if (PARK_ZERO) begin : g_park
         assign mem_dq_o = pins_q.dq_oe ? wdata_q : 8'h00;
      end else begin : g_hold
         assign mem_dq_o = wdata_q;
      end
   endgenerate

   // R3: driver on only under a low write strobe, never against output enable
   a_r3_no_contention : assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n && !mem_we_n);

   // R2: output enable low only in a selected read
   a_r2_read_strobes : assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> mem_we_n && !mem_ce_n);

   // R4: write strobe falls only after a cycle of selected setup
   a_r4_setup_first : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(!mem_ce_n) && $past(mem_oe_n));

   // R5: address stable while the chip stays selected
   a_r5_addr_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R9: write data steady across the strobe
   a_r9_data_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_o));

   // R8: end of a read deselects the chip
   a_r8_turn_gap : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> mem_ce_n);

endmodule

// File: rtl/asram_port.sv
module asram_port #(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   parameter int RD_CYC    = 2,
   parameter int WR_CYC    = 1,
   parameter int TURN_CYC  = 1,
   parameter bit PARK_ZERO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ready,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   import asram_pkg::*;

   localparam int MAX_CYC = (RD_CYC > WR_CYC) ?
                            ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC) :
                            ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC);
   localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   generate
      if (RD_CYC < 1) begin : g_bad_rd
         $error("RD_CYC must be at least 1");
      end
      if (WR_CYC < 1) begin : g_bad_wr
         $error("WR_CYC must be at least 1");
      end
      if (TURN_CYC < 1) begin : g_bad_turn
         $error("TURN_CYC must be at least 1");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("DATA_W must be 8 for this RAM");
      end
      if (ADDR_W < 1) begin : g_bad_aw
         $error("ADDR_W must be positive");
      end
   endgenerate

   asram_st_e         st_q;
   asram_st_e         st_d;
   logic              cnt_load;
   logic [CW-1:0]     cnt_val;
   logic              cnt_zero;
   logic              accept;
   logic              capture;

   asram_cnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .zero     (cnt_zero)
   );

   asram_fsm #(
      .RD_CYC   (RD_CYC),
      .WR_CYC   (WR_CYC),
      .TURN_CYC (TURN_CYC),
      .CW       (CW)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .we       (we),
      .cnt_zero (cnt_zero),
      .cnt_load (cnt_load),
      .cnt_val  (cnt_val),
      .st_q     (st_q),
      .st_d     (st_d),
      .accept   (accept),
      .capture  (capture),
      .ready    (ready)
   );

   asram_pins #(
      .ADDR_W    (ADDR_W),
      .PARK_ZERO (PARK_ZERO)
   ) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_d      (st_d),
      .accept    (accept),
      .addr      (addr),
      .wdata     (wdata),
      .mem_addr  (mem_addr),
      .mem_ce_n  (mem_ce_n),
      .mem_oe_n  (mem_oe_n),
      .mem_we_n  (mem_we_n),
      .mem_dq_o  (mem_dq_o),
      .mem_dq_oe (mem_dq_oe)
   );

   asram_rcap #(.DATA_W(DATA_W)) u_rcap (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .dq_in   (mem_dq_i),
      .rdata   (rdata),
      .rvalid  (rvalid)
   );

   // R7: no valid pulse while a write is on the pins
   a_r7_no_rvalid_write : assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !rvalid);

   // R1: an idle port leaves the RAM deselected
   a_r1_idle_deselect : assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> mem_ce_n && !mem_dq_oe);

endmodule

// File: tb/asram_port_tb.sv
`timescale 1ns/100ps
module asram_port_tb;

   localparam int RD  = 2;
   localparam int WR  = 1;
   localparam int TRN = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [14:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        ready;
   logic [7:0]  rdata;
   logic        rvalid;
   logic [14:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_o;
   logic [7:0]  mem_dq_i;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   asram_port #(
      .RD_CYC   (RD),
      .WR_CYC   (WR),
      .TURN_CYC (TRN)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .we        (we),
      .addr      (addr),
      .wdata     (wdata),
      .ready     (ready),
      .rdata     (rdata),
      .rvalid    (rvalid),
      .mem_addr  (mem_addr),
      .mem_ce_n  (mem_ce_n),
      .mem_oe_n  (mem_oe_n),
      .mem_we_n  (mem_we_n),
      .mem_dq_o  (mem_dq_o),
      .mem_dq_oe (mem_dq_oe),
      .mem_dq_i  (mem_dq_i)
   );

   // RAM model: low address byte selects a word; marker 5A when not reading
   logic [7:0] bmem [256];
   always @(posedge clk)
      if (!mem_ce_n && !mem_we_n)
         bmem[mem_addr[7:0]] <= mem_dq_o;
   assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? bmem[mem_addr[7:0]] : 8'h5A;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   // {is_write, address, data (expected data for reads)}
   localparam int NV = 10;
   localparam logic [23:0] VEC [NV] = '{
      {1'b1, 15'h0000, 8'hA5},
      {1'b1, 15'h7FFF, 8'h3C},
      {1'b1, 15'h1234, 8'h0F},
      {1'b1, 15'h4321, 8'hF0},
      {1'b0, 15'h7FFF, 8'h3C},
      {1'b0, 15'h0000, 8'hA5},
      {1'b0, 15'h1234, 8'h0F},
      {1'b1, 15'h1234, 8'h66},
      {1'b0, 15'h1234, 8'h66},
      {1'b0, 15'h4321, 8'hF0}
   };

   task automatic run_op(input logic w, input logic [14:0] a, input logic [7:0] d,
                         input logic intrude);
      int n, we_lo, oe_lo, clash, aerr, derr, rv_n, rv_cnt, n_rdy;
      logic setup_ok, turn_ok;
      logic [7:0] got;
      n = 0; we_lo = 0; oe_lo = 0; clash = 0; aerr = 0; derr = 0;
      rv_n = 0; rv_cnt = 0; n_rdy = -1; setup_ok = 1'b0; turn_ok = 1'b1; got = '0;
      while (!ready) @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      n = 1;
      for (int k = 0; k < 40; k++) begin
         if (!mem_ce_n && mem_addr !== a) aerr++;
         if (!mem_we_n) begin
            we_lo++;
            if (mem_dq_o !== d || !mem_dq_oe || mem_addr !== a) derr++;
         end
         if (!mem_oe_n) oe_lo++;
         if (mem_dq_oe && (!mem_oe_n || mem_we_n)) clash++;
         if (n == 1) setup_ok = !mem_ce_n && mem_we_n && mem_oe_n;
         if (!w && n > RD && n <= RD + TRN && !(mem_ce_n && mem_oe_n && mem_we_n)) turn_ok = 1'b0;
         if (rvalid) begin rv_cnt++; rv_n = n; got = rdata; end
         if (ready) begin n_rdy = n; break; end
         if (intrude && n == 1) begin
            req = 1'b1; we = 1'b1; addr = 15'h0055; wdata = 8'h99;
         end else begin
            req = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      req = 1'b0;
      if (w) begin
         check(n_rdy == WR + 2, "R6 write busy length", n_rdy, WR + 2);
         check(we_lo == WR, "R4 write strobe cycles", we_lo, WR);
         check(setup_ok, "R4 setup cycle strobes", setup_ok, 1);
         check(rv_cnt == 0, "R7 no rvalid on write", rv_cnt, 0);
         check(derr == 0, "R9 write data/address on pins", derr, 0);
      end else begin
         check(n_rdy == RD + TRN + 1, "R6 read busy length", n_rdy, RD + TRN + 1);
         check(oe_lo == RD, "R2 output enable cycles", oe_lo, RD);
         check(rv_cnt == 1 && rv_n == RD + 1, "R7 rvalid single and timed", rv_n, RD + 1);
         check(got == d, "R2 read data", got, d);
         check(turn_ok, "R8 turnaround strobes high", turn_ok, 1);
      end
      check(clash == 0 && we_lo >= 0, "R3 bus driver window", clash, 0);
      check(aerr == 0, "R5 address held", aerr, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
   end

   initial begin
      // R1: reset state, with a request held to show it is not taken
      req = 1'b1; we = 1'b1; addr = 15'h0011; wdata = 8'h77;
      repeat (3) @(negedge clk);
      check(ready === 1'b1, "R1 ready in reset", ready, 1);
      check({mem_ce_n, mem_oe_n, mem_we_n} === 3'b111, "R1 strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
      check(mem_dq_oe === 1'b0 && rvalid === 1'b0, "R1 driver and rvalid in reset",
            {mem_dq_oe, rvalid}, 0);
      req = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(ready === 1'b1 && mem_ce_n === 1'b1, "R1 idle after reset",
            {ready, mem_ce_n}, 3);

      // vector table walk, back to back
      for (int i = 0; i < NV; i++)
         run_op(VEC[i][23], VEC[i][22:8], VEC[i][7:0], 1'b0);

      // R6: request while busy must be ignored
      run_op(1'b1, 15'h0055, 8'h11, 1'b0);
      run_op(1'b0, 15'h1234, 8'h66, 1'b1);
      run_op(1'b0, 15'h0055, 8'h11, 1'b0);
      check(bmem[8'h55] == 8'h11, "R6 ignored request wrote nothing", bmem[8'h55], 8'h11);

      // R8: read then write at once, then write then read
      run_op(1'b0, 15'h7FFF, 8'h3C, 1'b0);
      run_op(1'b1, 15'h7FFF, 8'hC3, 1'b0);
      run_op(1'b0, 15'h7FFF, 8'hC3, 1'b0);

      // R7: idle gap shows no rvalid
      repeat (3) begin
         @(negedge clk);
         check(rvalid === 1'b0 && ready === 1'b1, "R7 no rvalid when idle",
               {rvalid, ready}, 1);
      end
      finish_up();
   end

endmodule